// File: doc/BRIEF.md
# Serial Transmitter with Line Break Generation

This block serializes characters onto an asynchronous line. Each frame is a low start bit, the data bits least significant first, an optional parity bit (even or odd), and one high stop bit. Bit timing comes from an external baud tick: one pulse per bit period, and the line changes only on those pulses. A one-entry holding register lets software queue the next character while the current one is on the wire, so characters can go out back to back.

A break works like a queued character. A start-break pulse reserves the next slot. When the shifter frees up, the line goes low and stays low until a stop-break pulse is taken. After the break the line is driven high for a guard interval before anything else is sent. The guard interval is the programmed guard value in bit periods, with a floor of twelve. Two flags report the state: ready (a write or command may be given) and empty (nothing queued, nothing on the wire).

Top module: `sertx_brk`

## Requirements
- R1: After reset, txd is 1 and both tx_ready and tx_empty are 1.
- R2: A frame is txd=0 for the start bit, then wr_data bit 0 up to bit 7, then a parity bit when par_en=1, then txd=1 for the stop bit. Each bit lasts one baud-tick period. The parity bit is the XOR of the data bits, inverted when par_odd=1. txd changes only at a clock edge where baud_tick was 1.
- R3: A write accepted while a frame is in flight is held and starts at the tick that ends the previous stop bit. tx_ready is 0 while the holding register is full, and a write given while tx_ready=0 is dropped.
- R4: A start-break pulse is taken only when tx_ready=1. The break begins at the first tick at which the shifter is free, which is right after any frame in flight. At that point tx_ready and tx_empty read 0. A start-break given with tx_ready=0 has no effect.
- R5: A write given while a break is queued but not yet begun is dropped. A write in the same cycle as an accepted start-break is also dropped.
- R6: During a break txd is 0. tx_ready returns to 1 once the break has lasted one frame length in bit periods. A stop-break taken then ends the break at the next tick, so the line stays low for frame length plus one bit periods. Writes given while the break is active are dropped.
- R7: A stop-break pulse with no break active is ignored. This covers an idle line and a break that is queued but not yet begun.
- R8: After a break, txd stays 1 for max(12, guard_len) bit periods. Only then can a queued character start, and it starts on the tick that ends that interval.
- R9: A start-break and a stop-break in the same cycle are both ignored.
- R10: tx_empty reads 0 throughout the post-break guard interval. It returns to 1 at the tick that ends the interval, provided nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| brk_start | input | 1 | Start-break command pulse |
| brk_stop | input | 1 | Stop-break command pulse |
| par_en | input | 1 | Add a parity bit to each frame |
| par_odd | input | 1 | Use odd parity when 1, even parity when 0 |
| guard_len | input | GUARD_W | Requested post-break idle time in bit periods |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | A write or break command can be accepted |
| tx_empty | output | 1 | Nothing is queued or being sent |

## Verification
A wrong sequencer state shows up on txd within one bit period: a break cut short or stretched, a missing or extra high interval, or a dropped character that appears anyway. A holding-register or pending-break flag left set or cleared by mistake shows up as tx_ready or tx_empty disagreeing with the line. It also shows up as a surplus or missing frame once the next tick launches the shifter. The bench logs the line and both flags once per bit period and compares run lengths and decoded frames against values computed from the frame length and the guard floor.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DATA  = 2'd1,
      ST_BRK   = 2'd2,
      ST_GUARD = 2'd3
   } tx_st_e;

   // bits in one frame: start + data + optional parity + stop
   function automatic int unsigned frame_bits(int unsigned dw, bit with_par);
      return dw + 2 + (with_par ? 1 : 0);
   endfunction

endpackage

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [DATA_W-1:0] data,
   output logic              line_bit
);

   localparam int unsigned SH_W = sertx_pkg::frame_bits(DATA_W, PARITY_EN);

   logic [SH_W-1:0] sreg_q;
   logic [SH_W-1:0] frame;

   generate
      if (PARITY_EN) begin : g_par
         logic pbit;
         // when parity is off the slot is filled with a mark; the
         // sequencer ends the frame before it is shifted out
         assign pbit  = par_en ? ((^data) ^ par_odd) : 1'b1;
         assign frame = {1'b1, pbit, data, 1'b0};
      end else begin : g_nopar
         logic unused_cfg;
         assign unused_cfg = par_en ^ par_odd;
         assign frame      = {1'b1, data, 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '1;
      end else if (load) begin
         sreg_q <= frame;
      end else if (shift) begin
         sreg_q <= {1'b1, sreg_q[SH_W-1:1]};
      end
   end

   assign line_bit = sreg_q[0];

endmodule

// File: rtl/sertx_guard.sv
module sertx_guard #(
   parameter int unsigned GUARD_W   = 8,
   parameter int unsigned MIN_GUARD = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               step,
   input  logic [GUARD_W-1:0] guard_len,
   output logic               last
);

   localparam logic [GUARD_W-1:0] FLOOR = GUARD_W'(MIN_GUARD);

   logic [GUARD_W-1:0] lim_q;
   logic [GUARD_W-1:0] cnt_q;
   logic [GUARD_W-1:0] lim_nx;

   assign lim_nx = (guard_len > FLOOR) ? guard_len : FLOOR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= FLOOR;
         cnt_q <= '0;
      end else if (arm) begin
         lim_q <= lim_nx;
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == lim_q - 1'b1);

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              brk_start,
   input  logic              brk_stop,
   input  logic              par_en,
   input  logic              line_bit,
   input  logic              guard_last,
   output logic              sh_load,
   output logic              sh_shift,
   output logic [DATA_W-1:0] sh_data,
   output logic              guard_arm,
   output logic              guard_step,
   output logic              txd,
   output logic              tx_ready,
   output logic              tx_empty
);

   localparam int unsigned FR_MAX = frame_bits(DATA_W, PARITY_EN);
   localparam int unsigned CNT_W  = $clog2(FR_MAX + 1);
   localparam logic [CNT_W-1:0] FR_BASE = CNT_W'(frame_bits(DATA_W, 1'b0));

   tx_st_e            st_q;
   logic [DATA_W-1:0] hold_q;
   logic              hold_full_q;
   logic              brk_pend_q;
   logic              stop_pend_q;
   logic [CNT_W-1:0]  bcnt_q;
   logic [CNT_W-1:0]  len_q;
   logic [CNT_W-1:0]  len_nx;

   logic in_brk, brk_min, last_data, free_slot;
   logic start_ok, stop_ok, wr_ok;
   logic launch_brk, launch_chr, end_brk;

   assign len_nx = FR_BASE + CNT_W'(PARITY_EN && par_en);

   assign in_brk    = (st_q == ST_BRK);
   assign brk_min   = (bcnt_q == len_q);
   assign last_data = (st_q == ST_DATA) && (bcnt_q == len_q - 1'b1);

   assign tx_ready = !hold_full_q && !(in_brk && (!brk_min || stop_pend_q));
   assign tx_empty = !hold_full_q && !brk_pend_q && (st_q == ST_IDLE);

   // a clash of both break commands is dropped as a whole
   assign start_ok = brk_start && !brk_stop && tx_ready && !brk_pend_q && !in_brk;
   assign stop_ok  = brk_stop && !brk_start && tx_ready && in_brk;
   assign wr_ok    = wr_en && tx_ready && !brk_pend_q && !in_brk && !start_ok;

   assign free_slot = baud_tick && ((st_q == ST_IDLE) || last_data ||
                                    ((st_q == ST_GUARD) && guard_last));
   assign launch_brk = free_slot && brk_pend_q;
   assign launch_chr = free_slot && !brk_pend_q && hold_full_q;
   assign end_brk    = baud_tick && in_brk && stop_pend_q;

   assign sh_load    = launch_chr;
   assign sh_shift   = baud_tick && (st_q == ST_DATA) && !last_data;
   assign sh_data    = hold_q;
   assign guard_arm  = end_brk;
   assign guard_step = baud_tick && (st_q == ST_GUARD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bcnt_q <= '0;
         len_q  <= FR_BASE;
      end else if (launch_brk) begin
         st_q   <= ST_BRK;
         bcnt_q <= '0;
         len_q  <= len_nx;
      end else if (launch_chr) begin
         st_q   <= ST_DATA;
         bcnt_q <= '0;
         len_q  <= len_nx;
      end else if (free_slot) begin
         st_q   <= ST_IDLE;
      end else if (end_brk) begin
         st_q   <= ST_GUARD;
      end else if (baud_tick && (st_q == ST_DATA)) begin
         bcnt_q <= bcnt_q + 1'b1;
      end else if (baud_tick && in_brk && !brk_min) begin
         bcnt_q <= bcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else if (wr_ok) begin
         hold_q      <= wr_data;
         hold_full_q <= 1'b1;
      end else if (launch_chr) begin
         hold_full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_pend_q  <= 1'b0;
         stop_pend_q <= 1'b0;
      end else begin
         if (start_ok)        brk_pend_q  <= 1'b1;
         else if (launch_brk) brk_pend_q  <= 1'b0;
         if (stop_ok)         stop_pend_q <= 1'b1;
         else if (end_brk)    stop_pend_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_DATA: txd = line_bit;
         ST_BRK:  txd = 1'b0;
         default: txd = 1'b1;
      endcase
   end

endmodule

// File: rtl/sertx_brk.sv
module sertx_brk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned GUARD_W   = 8,
   parameter int unsigned MIN_GUARD = 12,
   parameter bit          PARITY_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               brk_start,
   input  logic               brk_stop,
   input  logic               par_en,
   input  logic               par_odd,
   input  logic [GUARD_W-1:0] guard_len,
   output logic               txd,
   output logic               tx_ready,
   output logic               tx_empty
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_dw
         $error("sertx_brk: DATA_W must be 5..9");
      end
      if (MIN_GUARD < 1 || MIN_GUARD >= (1 << GUARD_W)) begin : g_bad_guard
         $error("sertx_brk: MIN_GUARD must fit in GUARD_W bits and be nonzero");
      end
   endgenerate

   logic              sh_load, sh_shift, line_bit;
   logic [DATA_W-1:0] sh_data;
   logic              guard_arm, guard_step, guard_last;

   sertx_seq #(
      .DATA_W    (DATA_W),
      .PARITY_EN (PARITY_EN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .brk_start  (brk_start),
      .brk_stop   (brk_stop),
      .par_en     (par_en),
      .line_bit   (line_bit),
      .guard_last (guard_last),
      .sh_load    (sh_load),
      .sh_shift   (sh_shift),
      .sh_data    (sh_data),
      .guard_arm  (guard_arm),
      .guard_step (guard_step),
      .txd        (txd),
      .tx_ready   (tx_ready),
      .tx_empty   (tx_empty)
   );

   sertx_shift #(
      .DATA_W    (DATA_W),
      .PARITY_EN (PARITY_EN)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .shift    (sh_shift),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .data     (sh_data),
      .line_bit (line_bit)
   );

   sertx_guard #(
      .GUARD_W   (GUARD_W),
      .MIN_GUARD (MIN_GUARD)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (guard_arm),
      .step      (guard_step),
      .guard_len (guard_len),
      .last      (guard_last)
   );

endmodule

// File: rtl/sertx_brk_chk.sv
module sertx_brk_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic wr_en,
   input logic brk_start,
   input logic brk_stop,
   input logic txd,
   input logic tx_ready,
   input logic tx_empty
);

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> txd);

   assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(baud_tick) |-> $stable(txd));

   assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_ready) |-> $past(baud_tick || wr_en || brk_stop));

   assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_stop && !brk_start && !wr_en && tx_empty) |=> tx_empty);

   assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_start && brk_stop && !wr_en && tx_empty) |=> tx_empty);

   assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_ready);

   assert_empty_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(baud_tick));

endmodule

bind sertx_brk sertx_brk_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .baud_tick (baud_tick),
   .wr_en     (wr_en),
   .brk_start (brk_start),
   .brk_stop  (brk_stop),
   .txd       (txd),
   .tx_ready  (tx_ready),
   .tx_empty  (tx_empty)
);

// File: tb/sertx_brk_tb_top.sv
module sertx_brk_tb_top;

   localparam int LOGN = 32768;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ph = 2'd0;
   logic       baud_tick;
   logic       wr_en = 1'b0, brk_start = 1'b0, brk_stop = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       par_en = 1'b0, par_odd = 1'b0;
   logic [7:0] guard_len = 8'd0;
   logic       txd, tx_ready, tx_empty;

   always #5 clk = ~clk;
   always_ff @(posedge clk) ph <= ph + 2'd1;
   assign baud_tick = (ph == 2'd0);

   sertx_brk dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .brk_start(brk_start), .brk_stop(brk_stop),
      .par_en(par_en), .par_odd(par_odd), .guard_len(guard_len),
      .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty));

   bit lg_txd [LOGN];
   bit lg_rdy [LOGN];
   bit lg_emp [LOGN];
   int logn = 0;
   bit log_on = 0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // one sample per bit period, mid-period
   always @(negedge clk) begin
      if (log_on && ph == 2'd2 && logn < LOGN) begin
         lg_txd[logn] = txd;
         lg_rdy[logn] = tx_ready;
         lg_emp[logn] = tx_empty;
         logn++;
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_wr(logic [7:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse_cmd(bit s, bit p);
      brk_start = s; brk_stop = p;
      @(negedge clk); brk_start = 1'b0; brk_stop = 1'b0;
   endtask

   task automatic wait_ticks(int n);
      repeat (n * 4) @(negedge clk);
   endtask

   task automatic wait_ready();
      while (!tx_ready) @(negedge clk);
   endtask

   task automatic wait_empty();
      while (!tx_empty) @(negedge clk);
   endtask

   task automatic wait_ph(logic [1:0] v);
      while (ph != v) @(negedge clk);
   endtask

   function automatic int find_lvl(int from, bit v);
      for (int i = from; i < logn; i++) if (lg_txd[i] == v) return i;
      return logn;
   endfunction

   function automatic int run_len(int from, bit v);
      int n = 0;
      for (int i = from; i < logn; i++) begin
         if (lg_txd[i] != v) break;
         n++;
      end
      return n;
   endfunction

   // compares a whole frame starting at log index p
   task automatic check_frame(int p, logic [7:0] d, bit pe, bit po, string req);
      int nb = 10 + (pe ? 1 : 0);
      int act = 0, exp = 0;
      bit eb [11];
      eb[0] = 1'b0;
      for (int i = 0; i < 8; i++) eb[i+1] = d[i];
      if (pe) begin
         eb[9] = (^d) ^ po;
         eb[10] = 1'b1;
      end else begin
         eb[9] = 1'b1;
      end
      for (int i = 0; i < nb; i++) begin
         exp |= int'(eb[i]) << i;
         if (p + i < logn) act |= int'(lg_txd[p+i]) << i;
         else act |= 1 << 12;
      end
      check(act == exp, req, act, exp);
   endtask

   task automatic sweep(int mode);
      bit pe = (mode != 0);
      bit po = (mode == 2);
      int nb = 10 + (pe ? 1 : 0);
      int l, p;
      par_en = pe; par_odd = po;
      wait_empty();
      l = logn;
      for (int b = 0; b < 256; b++) begin
         wait_ready();
         pulse_wr(8'(b));
      end
      wait_empty();
      wait_ticks(3);
      p = find_lvl(l, 1'b0);
      for (int b = 0; b < 256; b++) begin
         check_frame(p, 8'(b), pe, po, "R2 R3 frame/back-to-back");
         p += nb;
      end
      check(find_lvl(p, 1'b0) == logn, "R3 line idle after sweep", find_lvl(p, 1'b0), logn);
   endtask

   task automatic brk_case(int g, bit pe, bit with_chr, bit lead);
      int nb = 10 + (pe ? 1 : 0);
      int gg = (g > 12) ? g : 12;
      int l, p, q, lo, hi;
      guard_len = 8'(g); par_en = pe; par_odd = 1'b0;
      wait_empty();
      l = logn;
      if (lead) begin
         pulse_wr(8'hA5);
         wait_ready();
         pulse_cmd(1'b1, 1'b0);   // queued behind the frame
         pulse_cmd(1'b0, 1'b1);   // R7: no active break yet
         pulse_wr(8'h3C);         // R5: dropped while pending
      end else begin
         pulse_cmd(1'b1, 1'b0);
      end
      while (tx_ready) @(negedge clk);
      wait_ready();
      pulse_wr(8'h81);            // R6: dropped during break
      pulse_cmd(1'b0, 1'b1);
      if (with_chr) begin
         wait_ready();
         pulse_wr(8'h5A);
      end
      wait_ticks(gg + nb + 6);
      wait_empty();
      wait_ticks(3);
      p = find_lvl(l, 1'b0);
      if (lead) begin
         check_frame(p, 8'hA5, pe, 1'b0, "R4 frame before break");
         p += nb;
         check(lg_txd[p] == 1'b0, "R4 break right after frame", lg_txd[p], 0);
      end
      check(lg_rdy[p] == 1'b0 && lg_emp[p] == 1'b0, "R4 flags clear at break",
            int'(lg_rdy[p]) * 2 + int'(lg_emp[p]), 0);
      lo = run_len(p, 1'b0);
      check(lo == nb + 1, "R6 R7 break low length", lo, nb + 1);
      q = p + lo;
      hi = run_len(q, 1'b1);
      check(lg_emp[q + gg - 1] == 1'b0, "R10 empty low in guard", lg_emp[q + gg - 1], 0);
      if (with_chr) begin
         check(hi == gg, "R8 guard length", hi, gg);
         check_frame(q + gg, 8'h5A, pe, 1'b0, "R8 char after guard");
         check(find_lvl(q + gg + nb, 1'b0) == logn, "R5 R6 dropped writes absent",
               find_lvl(q + gg + nb, 1'b0), logn);
      end else begin
         check(hi == logn - q, "R5 R6 R8 line high after break", hi, logn - q);
         check(lg_emp[q + gg] == 1'b1, "R10 empty at guard end", lg_emp[q + gg], 1);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int l, p;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(txd == 1'b1 && tx_ready && tx_empty, "R1 reset state",
            int'(txd) * 4 + int'(tx_ready) * 2 + int'(tx_empty), 7);
      log_on = 1'b1;

      // R2/R3 exhaustive data sweep in three parity modes
      for (int m = 0; m < 3; m++) sweep(m);

      // R3 write while not ready is dropped
      par_en = 1'b0; wait_empty();
      l = logn;
      wait_ph(2'd1);
      pulse_wr(8'h96);
      check(tx_ready == 1'b0, "R3 ready low when holding full", tx_ready, 0);
      pulse_wr(8'h11);
      wait_ready();
      pulse_wr(8'hC3);
      wait_empty(); wait_ticks(3);
      p = find_lvl(l, 1'b0);
      check_frame(p, 8'h96, 1'b0, 1'b0, "R3 first frame");
      check_frame(p + 10, 8'hC3, 1'b0, 1'b0, "R3 queued frame");
      check(find_lvl(p + 20, 1'b0) == logn, "R3 dropped write absent", find_lvl(p + 20, 1'b0), logn);

      // R4 start-break while not ready has no effect
      l = logn;
      wait_ph(2'd1);
      pulse_wr(8'h0F);
      pulse_cmd(1'b1, 1'b0);
      wait_empty(); wait_ticks(20);
      p = find_lvl(l, 1'b0);
      check_frame(p, 8'h0F, 1'b0, 1'b0, "R4 frame");
      check(find_lvl(p + 10, 1'b0) == logn, "R4 no break when not ready", find_lvl(p + 10, 1'b0), logn);

      // R7 stop-break on an idle line
      l = logn;
      pulse_cmd(1'b0, 1'b1);
      wait_ticks(15);
      check(find_lvl(l, 1'b0) == logn && tx_empty && tx_ready, "R7 idle stop ignored",
            find_lvl(l, 1'b0), logn);

      // R9 both commands together
      l = logn;
      pulse_cmd(1'b1, 1'b1);
      wait_ticks(15);
      check(find_lvl(l, 1'b0) == logn && tx_empty, "R9 clash ignored", find_lvl(l, 1'b0), logn);
      l = logn;
      pulse_wr(8'h42);
      wait_empty(); wait_ticks(3);
      check_frame(find_lvl(l, 1'b0), 8'h42, 1'b0, 1'b0, "R9 normal after clash");

      // break scenarios over guard values around the floor
      brk_case(0,  1'b0, 1'b1, 1'b0);
      brk_case(5,  1'b1, 1'b1, 1'b0);
      brk_case(12, 1'b0, 1'b0, 1'b0);
      brk_case(13, 1'b1, 1'b1, 1'b1);
      brk_case(20, 1'b0, 1'b0, 1'b1);
      brk_case(30, 1'b1, 1'b1, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule